// File: doc/BRIEF.md
# Descending Word Stack with Indexed Frame Access

This unit holds the data stack of a small register-based processor core. Storage is a fixed array of words whose capacity is chosen at instantiation (256 by default). The stack begins at the highest word and grows toward lower addresses, so every push moves the top one word down. Besides push and pop, the core can read or write any slot by index. The index is a base register value plus a signed offset, and index 0 always names the bottom word, which is the highest physical address.

Every request is accepted on the cycle it is presented. Exactly one cycle later the unit answers with read data or with an error code. Stack faults are reported apart from bad indices: a full push or an empty pop gives one code, and an indexed access outside the array gives another. A rejected request changes neither the stored words nor the occupancy. A depth output always shows how many words are currently pushed.

Top module: `frame_stack`

## Requirements
- R1: After reset, `depth` is 0, `rsp_valid` is 0 and `rsp_err` is 0.
- R2: A push (op code 2'b00) that is not full stores `req_wdata` as the new top, one word below the previous top. `depth` then rises by one.
- R3: A push while `depth` equals the capacity is refused with `rsp_err` 2'b01. `depth` and all stored words stay unchanged.
- R4: A pop while `depth` is 0 is refused with `rsp_err` 2'b01, and `depth` stays 0.
- R5: A pop (op code 2'b01) on a non-empty stack returns the most recently pushed word not yet popped, and `depth` falls by one.
- R6: A load (op code 2'b10) returns the word at index `req_base + req_offset`. Both operands are signed 32-bit values. Index 0 is the first word ever pushed (the highest physical word), so index i is physical word capacity-1-i.
- R7: A store (op code 2'b11) with an index in range writes `req_wdata` to that index. A later load or pop of that slot returns it.
- R8: A load or store whose 33-bit signed sum is negative or not below the capacity is refused with `rsp_err` 2'b10 and writes nothing.
- R9: `rsp_valid` is high exactly on the cycle after each request and low otherwise. `rsp_data` is 0 for pushes, stores and every refused request.
- R10: Loads and stores never change `depth`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 push, 01 pop, 10 load, 11 store |
| req_wdata | input | DATA_W | Word to push or store |
| req_base | input | DATA_W | Base register value for indexed access |
| req_offset | input | DATA_W | Signed offset for indexed access |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Popped or loaded word, else 0 |
| rsp_err | output | 2 | 00 none, 01 stack fault, 10 bad index |
| depth | output | $clog2(DEPTH+1) | Number of words pushed |

## Verification
Every result is registered once. The response fields and the updated `depth` for a request presented before rising edge N become visible just after edge N, and are gone after edge N+1 unless another request follows. The bench drives each request on a falling edge, drops it on the next falling edge, and samples `rsp_*` and `depth` at that same falling edge, half a cycle after the capturing edge. Writes that were refused are checked by reading back the slot the wrapped index would have hit, and the full-stack case is reached by pushing to capacity.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [1:0] {
        OP_PUSH  = 2'b00,
        OP_POP   = 2'b01,
        OP_LOAD  = 2'b10,
        OP_STORE = 2'b11
    } fs_op_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_STACK = 2'b01,
        ERR_ADDR  = 2'b10
    } fs_err_e;

endpackage

// File: rtl/fs_index_calc.sv
// Converts base + signed offset into a physical word address and a range flag.
module fs_index_calc #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    output logic              in_range_o,
    output logic [AW-1:0]     phys_o
);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(DEPTH);
    localparam logic [AW-1:0]     TOP   = AW'(DEPTH - 1);

    logic [DATA_W:0] sum;

    always_comb begin
        sum        = {base_i[DATA_W-1], base_i} + {offset_i[DATA_W-1], offset_i};
        in_range_o = !sum[DATA_W] && (sum[DATA_W-1:0] < LIMIT);
        phys_o     = TOP - sum[AW-1:0];
    end
endmodule

// File: rtl/fs_ptr.sv
// Occupancy decode: full/empty flags and the physical slots for push and pop.
module fs_ptr #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count_i,
    output logic          full_o,
    output logic          empty_o,
    output logic [AW-1:0] push_addr_o,
    output logic [AW-1:0] pop_addr_o
);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] push_full;
    logic [CW-1:0] pop_full;

    always_comb begin
        full_o      = (count_i == CAP);
        empty_o     = (count_i == '0);
        push_full   = LAST - count_i;
        pop_full    = CAP - count_i;
        push_addr_o = push_full[AW-1:0];
        pop_addr_o  = pop_full[AW-1:0];
    end
endmodule

// File: rtl/fs_mem.sv
// Word array: one synchronous write port, one combinational read port.
module fs_mem #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            words[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = words[raddr_i];
endmodule

// File: rtl/frame_stack.sv
module frame_stack
    import fs_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_offset,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_err,
    output logic [CW-1:0]     depth
);
    typedef struct packed {
        logic [CW-1:0]     count;
        logic              valid;
        fs_err_e           err;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t state_d, state_q;

    logic              full, empty, in_range;
    logic [AW-1:0]     push_addr, pop_addr, idx_addr;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    fs_op_e            op;

    assign op = fs_op_e'(req_op);

    fs_ptr #(.DEPTH(DEPTH)) u_ptr (
        .count_i     (state_q.count),
        .full_o      (full),
        .empty_o     (empty),
        .push_addr_o (push_addr),
        .pop_addr_o  (pop_addr)
    );

    fs_index_calc #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_idx (
        .base_i     (req_base),
        .offset_i   (req_offset),
        .in_range_o (in_range),
        .phys_o     (idx_addr)
    );

    fs_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (req_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.err   = ERR_NONE;
        state_d.data  = '0;
        mem_we        = 1'b0;
        mem_waddr     = (op == OP_PUSH) ? push_addr : idx_addr;
        mem_raddr     = (op == OP_POP) ? pop_addr : idx_addr;
        if (req_valid) begin
            unique case (op)
                OP_PUSH: begin
                    if (full) begin
                        state_d.err = ERR_STACK;
                    end else begin
                        mem_we        = 1'b1;
                        state_d.count = state_q.count + 1'b1;
                    end
                end
                OP_POP: begin
                    if (empty) begin
                        state_d.err = ERR_STACK;
                    end else begin
                        state_d.data  = mem_rdata;
                        state_d.count = state_q.count - 1'b1;
                    end
                end
                OP_LOAD: begin
                    if (!in_range) begin
                        state_d.err = ERR_ADDR;
                    end else begin
                        state_d.data = mem_rdata;
                    end
                end
                OP_STORE: begin
                    if (!in_range) begin
                        state_d.err = ERR_ADDR;
                    end else begin
                        mem_we = 1'b1;
                    end
                end
                default: state_d.err = ERR_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.count <= '0;
            state_q.valid <= 1'b0;
            state_q.err   <= ERR_NONE;
            state_q.data  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.valid;
    assign rsp_data  = state_q.data;
    assign rsp_err   = state_q.err;
    assign depth     = state_q.count;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [DATA_W-1:0] req_base,
    input logic [DATA_W-1:0] req_offset,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic [1:0]        rsp_err,
    input logic [CW-1:0]     depth
);
    localparam logic [CW-1:0]     CAP   = CW'(DEPTH);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(DEPTH);

    logic [DATA_W:0] ref_sum;
    logic            ref_ok;
    logic            is_frame;

    assign ref_sum  = {req_base[DATA_W-1], req_base} + {req_offset[DATA_W-1], req_offset};
    assign ref_ok   = !ref_sum[DATA_W] && (ref_sum[DATA_W-1:0] < LIMIT);
    assign is_frame = req_valid && req_op[1];

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (depth == '0) && !rsp_valid && (rsp_err == 2'b00));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && depth != CAP)
        |=> (depth == $past(depth) + 1'b1) && (rsp_err == 2'b00));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && depth == CAP)
        |=> (rsp_err == 2'b01) && (depth == CAP));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && depth == '0)
        |=> (rsp_err == 2'b01) && (depth == '0));

    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && depth != '0)
        |=> (depth == $past(depth) - 1'b1) && (rsp_err == 2'b00));

    p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_frame && !ref_ok) |=> (rsp_err == 2'b10));

    p_good_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_frame && ref_ok) |=> (rsp_err == 2'b00));

    p_rsp_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != 2'b00) |-> (rsp_data == '0));

    p_frame_keeps_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_frame |=> $stable(depth));

    p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CAP);
endmodule

bind frame_stack fs_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_base   (req_base),
    .req_offset (req_offset),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err),
    .depth      (depth)
);

// File: tb/frame_stack_bench.sv
`timescale 1ns/1ps
module frame_stack_bench;
    localparam int DEPTH  = 256;
    localparam int DATA_W = 32;
    localparam int CW     = $clog2(DEPTH + 1);

    localparam logic [1:0] PUSH = 2'b00, POP = 2'b01, LOAD = 2'b10, STORE = 2'b11;
    localparam logic [1:0] E_OK = 2'b00, E_STK = 2'b01, E_ADR = 2'b10;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] base;
        logic [31:0] off;
        logic [31:0] wdata;
        logic [1:0]  err;
        logic [31:0] data;
        logic [8:0]  dep;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{PUSH,  32'd0, 32'd0, 32'h11, E_OK, 32'h0, 9'd1},          // R2
        '{PUSH,  32'd0, 32'd0, 32'h22, E_OK, 32'h0, 9'd2},          // R2
        '{PUSH,  32'd0, 32'd0, 32'h33, E_OK, 32'h0, 9'd3},          // R2
        '{LOAD,  32'd0, 32'd0, 32'h0, E_OK, 32'h11, 9'd3},          // R6 bottom
        '{LOAD,  32'd1, 32'd1, 32'h0, E_OK, 32'h33, 9'd3},          // R6
        '{STORE, 32'd0, 32'd1, 32'hAB, E_OK, 32'h0, 9'd3},          // R7
        '{LOAD,  32'd2, 32'hFFFFFFFF, 32'h0, E_OK, 32'hAB, 9'd3},   // R6 negative offset
        '{STORE, 32'd200, 32'd55, 32'h77, E_OK, 32'h0, 9'd3},       // R7 last index
        '{LOAD,  32'd255, 32'd0, 32'h0, E_OK, 32'h77, 9'd3},        // R7
        '{STORE, 32'd0, 32'hFFFFFFFF, 32'hDEAD, E_ADR, 32'h0, 9'd3},// R8 negative
        '{LOAD,  32'd255, 32'd0, 32'h0, E_OK, 32'h77, 9'd3},        // R8 no write
        '{STORE, 32'd0, 32'd256, 32'hBEEF, E_ADR, 32'h0, 9'd3},     // R8 at capacity
        '{LOAD,  32'd0, 32'd0, 32'h0, E_OK, 32'h11, 9'd3},          // R8 no write
        '{LOAD,  32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, E_ADR, 32'h0, 9'd3}, // R8
        '{LOAD,  32'h80000000, 32'h80000000, 32'h0, E_ADR, 32'h0, 9'd3}, // R8
        '{POP,   32'd0, 32'd0, 32'h0, E_OK, 32'h33, 9'd2},          // R5
        '{POP,   32'd0, 32'd0, 32'h0, E_OK, 32'hAB, 9'd1},          // R5
        '{POP,   32'd0, 32'd0, 32'h0, E_OK, 32'h11, 9'd0},          // R5
        '{POP,   32'd0, 32'd0, 32'h0, E_STK, 32'h0, 9'd0},          // R4
        '{PUSH,  32'd0, 32'd0, 32'h44, E_OK, 32'h0, 9'd1},          // R2
        '{LOAD,  32'd0, 32'd0, 32'h0, E_OK, 32'h44, 9'd1},          // R6
        '{POP,   32'd0, 32'd0, 32'h0, E_OK, 32'h44, 9'd0}           // R5
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] req_base = '0;
    logic [DATA_W-1:0] req_offset = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0]        rsp_err;
    logic [CW-1:0]     depth;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    frame_stack #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_frame_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_wdata  (req_wdata),
        .req_base   (req_base),
        .req_offset (req_offset),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .depth      (depth)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic issue(input logic [1:0] op, input logic [31:0] b, input logic [31:0] o,
                         input logic [31:0] w);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_base   = b;
        req_offset = o;
        req_wdata  = w;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 depth after reset", 32'(depth), 32'd0);
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 rsp_err after reset", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].base, VECS[i].off, VECS[i].wdata);
            check($sformatf("R9 vec %0d rsp_valid", i), 32'(rsp_valid), 32'd1);
            check($sformatf("R2-R8 vec %0d err", i), 32'(rsp_err), 32'(VECS[i].err));
            check($sformatf("R5/R6 vec %0d data", i), rsp_data, VECS[i].data);
            check($sformatf("R10 vec %0d depth", i), 32'(depth), 32'(VECS[i].dep));
        end

        @(negedge clk);
        check("R9 idle rsp_valid", 32'(rsp_valid), 32'd0);

        // Fill to capacity
        for (int k = 0; k < DEPTH; k++) begin
            issue(PUSH, 32'd0, 32'd0, 32'h1000 + 32'(k));
            if (rsp_err !== E_OK) check("R2 fill push err", 32'(rsp_err), 32'(E_OK));
        end
        check("R2 depth at capacity", 32'(depth), 32'(DEPTH));

        issue(PUSH, 32'd0, 32'd0, 32'hCAFE);
        check("R3 full push err", 32'(rsp_err), 32'(E_STK));
        check("R3 full push depth", 32'(depth), 32'(DEPTH));
        check("R9 full push data", rsp_data, 32'h0);

        issue(LOAD, 32'd255, 32'd0, 32'h0);
        check("R3 top not overwritten", rsp_data, 32'h10FF);
        issue(LOAD, 32'd0, 32'd0, 32'h0);
        check("R6 bottom after fill", rsp_data, 32'h1000);

        issue(POP, 32'd0, 32'd0, 32'h0);
        check("R5 pop from full data", rsp_data, 32'h10FF);
        check("R5 pop from full depth", 32'(depth), 32'(DEPTH - 1));

        // Reset in mid-use
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 depth after second reset", 32'(depth), 32'd0);
        check("R1 rsp_valid after second reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule